// File: doc/BRIEF.md
# Shared-Counter Ramp ADC Sequencer

This block is the digital controller of a multi-channel ramp (Wilkinson) converter. One up-counter serves every channel. When a conversion pass is requested, the block first holds the analog ramp in reset for a programmable number of cycles. It then releases the ramp and counts up from zero, one step per clock, until the counter reaches its full-scale value. Each channel has its own comparator flag. The moment that flag rises, the channel captures the shared count into its own result register. A channel whose comparator never rises during the count receives the full-scale code together with an overflow flag.

One conversion covers one analog memory slot for all channels at once. A pass repeats the conversion for every occupied slot, starting at slot zero and going up in order. After the last slot the block emits a single-cycle done pulse. The analog ramp and the comparators are outside this block.

The controller is a five-state machine:
- IDLE waits for a start request.
- RAMP_RST holds the ramp in reset.
- COUNT enables the ramp and advances the counter.
- FILL closes the slot and gives the full-scale code to every channel that has not captured.
- DONE pulses completion.

The transitions are:
- IDLE→RAMP_RST on a start request with at least one slot.
- IDLE→DONE on a start request with zero slots.
- RAMP_RST→COUNT once the programmed reset length has elapsed.
- COUNT→FILL when the counter reaches full scale.
- FILL→RAMP_RST when more slots remain.
- FILL→DONE after the last slot.
- DONE→IDLE always.

Top module: `wk_adc_seq`

## Requirements
- R1: After reset, ramp_rst_o, ramp_en_o, done_o, every valid_o bit and every ovf_o bit are 0, and slot_o is 0.
- R2: After a start request with a nonzero slot count, and again before every later slot, ramp_rst_o is high for exactly rst_len_i+1 consecutive cycles, where rst_len_i is sampled at the start request. ramp_rst_o and ramp_en_o are never high together.
- R3: ramp_en_o stays high for exactly 2^CNT_W cycles per slot. The shared count is 0 in the first enabled cycle and rises by one in each following cycle, stopping at 2^CNT_W-1.
- R4: A channel whose comparator is low in one enabled cycle and high in the enabled cycle k (counting from 0) reports result k, with its valid bit set and its overflow bit clear. Channel c occupies bits [c*CNT_W +: CNT_W] of result_o.
- R5: Within one slot only the first rising edge of a channel's comparator is captured. Later falls and rises leave that channel's result unchanged.
- R6: A channel with no rising comparator edge during the enabled cycles of a slot reports result 2^CNT_W-1, with both its valid bit and its overflow bit set.
- R7: In the cycle after a slot's counting ends, every valid bit is 1. The valid and overflow bits are 0 again by the first enabled cycle of the next slot.
- R8: slot_o takes the values 0,1,…,N-1 in order, one slot per conversion, where N is slots_i sampled at start. A slot count above MAX_SLOTS is treated as MAX_SLOTS.
- R9: done_o is high for exactly one cycle, in the cycle after the last slot's counting ends. A start request with zero slots produces done_o in the next cycle, with no ramp activity.
- R10: A start request that arrives while a pass is in progress has no effect: the pass keeps its slot count and finishes at the expected time, and the block then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request for a conversion pass |
| slots_i | input | $clog2(MAX_SLOTS)+1 | Number of occupied memory slots |
| rst_len_i | input | RLEN_W | Ramp reset length minus one, in cycles |
| cmp_i | input | NUM_CH | Per-channel comparator flags |
| ramp_rst_o | output | 1 | Hold the analog ramp in reset |
| ramp_en_o | output | 1 | Ramp running, counter advancing |
| slot_o | output | $clog2(MAX_SLOTS) | Index of the slot being converted |
| result_o | output | NUM_CH*CNT_W | Packed per-channel conversion results |
| valid_o | output | NUM_CH | Per-channel result captured or filled |
| ovf_o | output | NUM_CH | Per-channel overflow (no comparator edge) |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bench builds the block with 4 channels and a 6-bit counter, keeping MAX_SLOTS at 16 and the reset-length width at 4. The short 64-cycle count lets it reach both ends of the code range on every slot: a capture at count 0, a capture at count 63, and the never-flipping channel that produces the overflow. Because a slot is short, a full 16-slot pass fits comfortably, so the slot-count clamp can be checked with a request of 20. A reset length of 15 covers the top of the 4-bit reset-length range.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP_RST,
        ST_COUNT,
        ST_FILL,
        ST_DONE
    } wk_state_e;

endpackage

// File: rtl/wk_ctrl.sv
module wk_ctrl
    import wk_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int MAX_SLOTS = 16,
    parameter int RLEN_W    = 8,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SLOT_W:0]   slots_i,
    input  logic [RLEN_W-1:0] rst_len_i,
    output logic              ramp_rst_o,
    output logic              ramp_en_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              clr_o,
    output logic              fill_o,
    output logic              done_o
);

    localparam logic [CNT_W-1:0] CMAX      = {CNT_W{1'b1}};
    localparam logic [SLOT_W:0]  SLOTS_CAP = MAX_SLOTS[SLOT_W:0];

    wk_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [RLEN_W-1:0] rcnt_q, rlen_q;
    logic [SLOT_W:0]   slots_q;
    logic [SLOT_W-1:0] slot_q;
    logic              last_slot;

    assign last_slot = ({1'b0, slot_q} == (slots_q - 1'b1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = (slots_i == '0) ? ST_DONE : ST_RAMP_RST;
            ST_RAMP_RST: if (rcnt_q == rlen_q) state_d = ST_COUNT;
            ST_COUNT:    if (cnt_q == CMAX) state_d = ST_FILL;
            ST_FILL:     state_d = last_slot ? ST_DONE : ST_RAMP_RST;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rcnt_q  <= '0;
            rlen_q  <= '0;
            slots_q <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        slots_q <= (slots_i > SLOTS_CAP) ? SLOTS_CAP : slots_i;
                        rlen_q  <= rst_len_i;
                        slot_q  <= '0;
                        rcnt_q  <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_RAMP_RST: begin
                    rcnt_q <= rcnt_q + 1'b1;
                    cnt_q  <= '0;
                end
                ST_COUNT: begin
                    if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
                end
                ST_FILL: begin
                    rcnt_q <= '0;
                    if (!last_slot) slot_q <= slot_q + 1'b1;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        ramp_rst_o = 1'b0;
        ramp_en_o  = 1'b0;
        clr_o      = 1'b0;
        fill_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_RAMP_RST: begin ramp_rst_o = 1'b1; clr_o = 1'b1; end
            ST_COUNT:    ramp_en_o = 1'b1;
            ST_FILL:     fill_o = 1'b1;
            ST_DONE:     done_o = 1'b1;
            default:     ;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign slot_o = slot_q;

    AST_RST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_rst_o && ramp_en_o)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_en_o && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
    AST_CNT_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_rst_o |=> (cnt_q == '0)); // R3
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_o |-> ({1'b0, slot_q} < slots_q)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> $stable(slots_q)); // R10

endmodule

// File: rtl/wk_chan.sv
module wk_chan #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             fill_i,
    input  logic             cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] res_o,
    output logic             valid_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic cmp_prev_q;
    logic rise;

    assign rise = cmp_i && !cmp_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_prev_q <= 1'b0;
            res_o      <= '0;
            valid_o    <= 1'b0;
            ovf_o      <= 1'b0;
        end else begin
            cmp_prev_q <= cmp_i;
            if (clr_i) begin
                valid_o <= 1'b0;
                ovf_o   <= 1'b0;
            end else if (en_i && rise && !valid_o) begin
                res_o   <= cnt_i;
                valid_o <= 1'b1;
            end else if (fill_i && !valid_o) begin
                res_o   <= CMAX;
                valid_o <= 1'b1;
                ovf_o   <= 1'b1;
            end
        end
    end

    AST_FIRST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !clr_i) |=> (valid_o && $stable(res_o))); // R5
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (valid_o && res_o == CMAX)); // R6
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!valid_o && !ovf_o)); // R7

endmodule

// File: rtl/wk_adc_seq.sv
module wk_adc_seq #(
    parameter int NUM_CH    = 36,
    parameter int CNT_W     = 12,
    parameter int MAX_SLOTS = 16,
    parameter int RLEN_W    = 8,
    localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [SLOT_W:0]         slots_i,
    input  logic [RLEN_W-1:0]       rst_len_i,
    input  logic [NUM_CH-1:0]       cmp_i,
    output logic                    ramp_rst_o,
    output logic                    ramp_en_o,
    output logic [SLOT_W-1:0]       slot_o,
    output logic [NUM_CH*CNT_W-1:0] result_o,
    output logic [NUM_CH-1:0]       valid_o,
    output logic [NUM_CH-1:0]       ovf_o,
    output logic                    done_o
);

    logic [CNT_W-1:0] cnt;
    logic             clr, fill;

    wk_ctrl #(
        .CNT_W     (CNT_W),
        .MAX_SLOTS (MAX_SLOTS),
        .RLEN_W    (RLEN_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .slots_i    (slots_i),
        .rst_len_i  (rst_len_i),
        .ramp_rst_o (ramp_rst_o),
        .ramp_en_o  (ramp_en_o),
        .cnt_o      (cnt),
        .slot_o     (slot_o),
        .clr_o      (clr),
        .fill_o     (fill),
        .done_o     (done_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        wk_chan #(
            .CNT_W (CNT_W)
        ) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .en_i    (ramp_en_o),
            .fill_i  (fill),
            .cmp_i   (cmp_i[c]),
            .cnt_i   (cnt),
            .res_o   (result_o[c*CNT_W +: CNT_W]),
            .valid_o (valid_o[c]),
            .ovf_o   (ovf_o[c])
        );
    end

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ramp_rst_o && !ramp_en_o)); // R9
    AST_ALL_VALID_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (valid_o == {NUM_CH{1'b1}})); // R7

endmodule

// File: tb/wk_adc_seq_tb_top.sv
module wk_adc_seq_tb_top;

    localparam int NUM_CH    = 4;
    localparam int CNT_W     = 6;
    localparam int MAX_SLOTS = 16;
    localparam int RLEN_W    = 4;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int CMAX      = (1 << CNT_W) - 1;
    localparam int NEVER     = CMAX + 1;
    localparam int NV        = 6;

    // per-slot comparator rise cycle for each channel; NEVER means no edge
    localparam logic [6:0] VEC [NV][NUM_CH] = '{
        '{7'd0,  7'd10, 7'd63, 7'd64},
        '{7'd5,  7'd5,  7'd5,  7'd5},
        '{7'd64, 7'd64, 7'd1,  7'd62},
        '{7'd30, 7'd20, 7'd40, 7'd0},
        '{7'd63, 7'd64, 7'd2,  7'd33},
        '{7'd64, 7'd64, 7'd64, 7'd64}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic [SLOT_W:0]         slots_i = '0;
    logic [RLEN_W-1:0]       rst_len_i = '0;
    logic [NUM_CH-1:0]       cmp_i = '0;
    logic                    ramp_rst_o, ramp_en_o, done_o;
    logic [SLOT_W-1:0]       slot_o;
    logic [NUM_CH*CNT_W-1:0] result_o;
    logic [NUM_CH-1:0]       valid_o, ovf_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wk_adc_seq #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .MAX_SLOTS(MAX_SLOTS), .RLEN_W(RLEN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .slots_i(slots_i),
        .rst_len_i(rst_len_i), .cmp_i(cmp_i), .ramp_rst_o(ramp_rst_o),
        .ramp_en_o(ramp_en_o), .slot_o(slot_o), .result_o(result_o),
        .valid_o(valid_o), .ovf_o(ovf_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one full pass; vec_base selects the first table row used
    task automatic run_pass(input int req_slots, input int rlen, input int exp_slots,
                            input int vec_base, input bit poke_busy);
        int rc;
        int k;
        int t;
        int exp_r;
        @(negedge clk);
        slots_i   = req_slots[SLOT_W:0];
        rst_len_i = rlen[RLEN_W-1:0];
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        for (int s = 0; s < exp_slots; s++) begin
            int row;
            row = (vec_base + s) % NV;
            rc = 0;
            while (!ramp_en_o) begin
                if (ramp_rst_o) rc++;
                @(negedge clk);
            end
            chk(rc == rlen + 1, "R2 ramp reset length", rc, rlen + 1);
            chk(valid_o == '0 && ovf_o == '0, "R7 flags cleared at count start",
                int'({ovf_o, valid_o}), 0);
            chk(int'(slot_o) == s, "R8 slot index", int'(slot_o), s);
            k = 0;
            while (ramp_en_o) begin
                if (ramp_rst_o) chk(1'b0, "R2 reset during enable", 1, 0);
                for (int c = 0; c < NUM_CH; c++) begin
                    t = int'(VEC[row][c]);
                    // first rise at t, drop at t+3, second rise at t+5 (R5)
                    cmp_i[c] = (k >= t && k < t + 3) || (k >= t + 5);
                end
                start_i = poke_busy && (s == 0) && (k == 10);
                k++;
                @(negedge clk);
            end
            start_i = 1'b0;
            cmp_i   = '0;
            chk(k == CMAX + 1, "R3 enable length", k, CMAX + 1);
            @(negedge clk);
            for (int c = 0; c < NUM_CH; c++) begin
                t = int'(VEC[row][c]);
                exp_r = (t >= NEVER) ? CMAX : t;
                chk(int'(result_o[c*CNT_W +: CNT_W]) == exp_r,
                    (t >= NEVER) ? "R6 overflow code" : "R4/R5 captured count",
                    int'(result_o[c*CNT_W +: CNT_W]), exp_r);
                chk(ovf_o[c] == (t >= NEVER), "R6 overflow flag", int'(ovf_o[c]),
                    int'(t >= NEVER));
            end
            chk(valid_o == '1, "R7 all valid after slot", int'(valid_o), (1 << NUM_CH) - 1);
            chk(done_o == (s == exp_slots - 1), "R9 done timing", int'(done_o),
                int'(s == exp_slots - 1));
        end
        @(negedge clk);
        chk(!done_o, "R9 done one cycle", int'(done_o), 0);
        repeat (3) begin
            chk(!ramp_rst_o && !ramp_en_o, "R10 idle after pass",
                int'({ramp_rst_o, ramp_en_o}), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int n = 0; n < 200000; n++) @(posedge clk);
        chk(1'b0, "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ramp_rst_o && !ramp_en_o && !done_o, "R1 control outputs",
            int'({ramp_rst_o, ramp_en_o, done_o}), 0);
        chk(valid_o == '0 && ovf_o == '0 && slot_o == '0, "R1 flags and slot",
            int'({slot_o, ovf_o, valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: every vector row once
        run_pass(NV, 2, NV, 0, 1'b0);

        // R8 clamp of an oversized slot count, R10 busy start poked mid-pass
        run_pass(20, 0, MAX_SLOTS, 3, 1'b1);

        // R2 longest reset length, single slot
        run_pass(1, 15, 1, 4, 1'b0);

        // R9 zero slots: done next cycle, no ramp activity
        @(negedge clk);
        slots_i = '0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !ramp_rst_o && !ramp_en_o, "R9 zero-slot done",
            int'({done_o, ramp_rst_o, ramp_en_o}), 4);
        @(negedge clk);
        chk(!done_o && !ramp_rst_o, "R9 zero-slot single pulse",
            int'({done_o, ramp_rst_o}), 0);

        finish_run();
    end

endmodule